// File: doc/BRIEF.md
# IR receive pulse/space sampler

This block watches a demodulated infrared receiver line and measures how long the line stays high (a pulse) and how long it stays low (a space). Each run becomes one byte: the top bit gives the polarity and the low seven bits give the run length in whole sample periods. The bytes go into an eight-byte store used as two halves of four. The host reads the store through a small register bus and is told which half it may read.

The sample period is set in microseconds. A run that lasts 127 periods is reported as a saturated byte, and counting of that same run then starts again. An interrupt is raised each time a half fills. It can also be raised on saturated bytes. Once the line has stayed low for longer than a set idle time, the block produces no more bytes until the line goes high again. A master enable clears the counters and the write position.

Bus map: byte addresses 0x0 to 0x7 are the sample store. 0x8 is control (bit 0 enable). 0x9 is the timing register: bits 6:0 give the period in µs and bit 7 enables the saturation interrupt. 0xA is status: bit 0 is the ready half and bit 1 is the interrupt flag. Reads are combinational. A write takes effect on the clock edge where `bus_we_i` is high.

Top module: `ir_rx_sampler`

## Requirements
- R1: A byte is stored each time the synchronised line changes level. Bit 7 is 1 for a space (line low) and 0 for a pulse (line high). Bits 6:0 give the number of whole sample periods the run lasted.
- R2: The sample period is the value in bits 6:0 of register 0x9, in microseconds. A value of 0 counts as 1. Microseconds are derived from CLKS_PER_US clock cycles.
- R3: When a run reaches 127 periods, a byte with bits 6:0 = 0x7F is stored. Counting of that same run restarts from zero, and its final byte carries the remainder.
- R4: Bytes are stored at addresses 0 to 7 in order, wrapping from 7 back to 0, and can be read back at those bus addresses.
- R5: When a byte is stored at address 3, status bit 0 becomes 0. When a byte is stored at address 7, status bit 0 becomes 1. In both cases the interrupt flag is set.
- R6: Storing a saturated byte sets the interrupt flag only while bit 7 of register 0x9 is 1.
- R7: Writing 0xA with bit 1 = 1 clears the interrupt flag. Writing 0xA with bit 1 = 0 leaves it unchanged. `irq_o` follows the flag.
- R8: After the line has been low for IDLE_US microseconds, no further bytes are stored. This covers saturated bytes and the byte that would end that space. The next pulse is measured normally.
- R9: While enable is 0, no bytes are stored and the write position returns to 0. After enable is set, the first byte goes to address 0, and the low level already present is not reported as a space.
- R10: After reset, the interrupt flag, status, control and timing registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 1 | Demodulated IR line, high = pulse |
| bus_addr_i | input | 4 | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the long-gap cutoff. It only shows up once a space has outlasted one full saturation, so a saturated space byte must land before the cutoff and nothing may follow it. The stimulus holds the line low across both thresholds, with a small idle parameter in the bench, while the scoreboard expects exactly one saturated space byte. The next pulse must then give a correct length and no stray space byte. A second hard case is a half filling while the host is still draining the previous one: the saturating 130-period pulse writes its saturated byte partway through the run.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int SMP_W     = 8;
  localparam int LEN_W     = 7;
  localparam int BUF_DEPTH = 8;
  localparam int PTR_W     = $clog2(BUF_DEPTH);
  localparam int ADDR_W    = 4;

  localparam logic [LEN_W-1:0]  LEN_SAT     = 7'h7F;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_TIMING = 4'h9;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'hA;

  typedef struct packed {
    logic             space;
    logic [LEN_W-1:0] len;
  } smp_t;
endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ir_rx_timebase.sv
module ir_rx_timebase #(
  parameter int CLKS_PER_US = 125,
  parameter int LEN_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] period_i,
  output logic             us_tick_o,
  output logic             smp_tick_o
);
  localparam int PRE_W = $clog2(CLKS_PER_US);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LEN_W-1:0] per_q, per_d, per_last;
  logic             run;

  always_comb begin
    run       = en_i && !restart_i;
    per_last  = (period_i == '0) ? '0 : period_i - 1'b1;
    us_tick_o = run && (pre_q == PRE_LAST);
    smp_tick_o = us_tick_o && (per_q == per_last);
    if (!run)           pre_d = '0;
    else if (us_tick_o) pre_d = '0;
    else                pre_d = pre_q + 1'b1;
    if (!run)            per_d = '0;
    else if (smp_tick_o) per_d = '0;
    else if (us_tick_o)  per_d = per_q + 1'b1;
    else                 per_d = per_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      per_q <= '0;
    end else begin
      pre_q <= pre_d;
      per_q <= per_d;
    end
  end

  // R2: a restart re-aligns the microsecond prescaler
  p_restart_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (pre_q == '0));
  // R2: sample ticks only fall on microsecond ticks
  p_tick_nest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_tick_o |-> us_tick_o);
endmodule

// File: rtl/ir_rx_runlen.sv
module ir_rx_runlen
  import ir_rx_pkg::*;
#(
  parameter int IDLE_US = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic us_tick_i,
  input  logic smp_tick_i,
  output logic edge_o,
  output logic smp_vld_o,
  output smp_t smp_o
);
  localparam int IDLE_W = $clog2(IDLE_US + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_US - 1);

  logic              lvl_q, lvl_d;
  logic              idle_q, idle_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [IDLE_W-1:0] gap_q, gap_d;
  logic              sat;

  always_comb begin
    edge_o = en_i && (lvl_i != lvl_q);
    sat    = en_i && !edge_o && smp_tick_i && (cnt_q == LEN_SAT - 1'b1);
    lvl_d  = en_i ? lvl_i : 1'b0;

    if (!en_i || edge_o || sat) cnt_d = '0;
    else if (smp_tick_i)        cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;

    if (!en_i)                                        idle_d = 1'b1;
    else if (edge_o)                                  idle_d = idle_q && !lvl_i;
    else if (us_tick_i && !lvl_q && gap_q == IDLE_LAST) idle_d = 1'b1;
    else                                              idle_d = idle_q;

    if (!en_i || edge_o)                  gap_d = '0;
    else if (us_tick_i && !lvl_q && !idle_q) gap_d = gap_q + 1'b1;
    else                                  gap_d = gap_q;

    smp_vld_o   = (edge_o || sat) && !idle_q;
    smp_o.space = !lvl_q;
    smp_o.len   = sat ? LEN_SAT : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      idle_q <= 1'b1;
      cnt_q  <= '0;
      gap_q  <= '0;
    end else begin
      lvl_q  <= lvl_d;
      idle_q <= idle_d;
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
    end
  end

  // R1: a level change starts the new run from zero
  p_edge_restarts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (cnt_q == '0));
  // R8: once idle, a steady low line keeps the block idle
  p_idle_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q && en_i && !lvl_i) |=> idle_q);
  // R3: the run counter never reaches the saturation code itself
  p_cnt_below_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_tick_i |=> (cnt_q != LEN_SAT));
endmodule

// File: rtl/ir_rx_sbuf.sv
module ir_rx_sbuf
  import ir_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic [PTR_W-1:0] rd_addr_i,
  output logic [SMP_W-1:0] rd_data_o,
  output logic             half_o,
  output logic             fill_o
);
  logic [SMP_W-1:0] mem_q [BUF_DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic             half_q, half_d;
  logic             wr_ok;

  always_comb begin
    wr_ok  = en_i && wr_i;
    fill_o = wr_ok && (wptr_q[PTR_W-2:0] == '1);
    if (!en_i)      wptr_d = '0;
    else if (wr_ok) wptr_d = wptr_q + 1'b1;
    else            wptr_d = wptr_q;
    half_d = fill_o ? wptr_q[PTR_W-1] : half_q;
  end

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (wr_ok && wptr_q == PTR_W'(g))     mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      half_q <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      half_q <= half_d;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign half_o    = half_q;

  // R4: each stored byte advances the write position by one
  p_ptr_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (wptr_q == $past(wptr_q) + 1'b1));
  // R9: disabling returns the write position to the first byte
  p_disable_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (wptr_q == '0));
  // R4: the stored byte is readable at its address
  p_byte_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (mem_q[$past(wptr_q)] == $past(data_i)));
endmodule

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler
  import ir_rx_pkg::*;
#(
  parameter int CLKS_PER_US = 125,
  parameter int IDLE_US     = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [SMP_W-1:0]  bus_wdata_i,
  output logic [SMP_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic             ir_s;
  logic             en_q, en_d;
  logic [SMP_W-1:0] timing_q, timing_d;
  logic             irq_q, irq_d;
  logic             us_tick, smp_tick, edge_det, smp_vld;
  smp_t             smp;
  logic [SMP_W-1:0] buf_rdata;
  logic             half, fill;
  logic             irq_set, irq_ack, ovf_hit;

  ir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ir_i), .q_o(ir_s)
  );

  ir_rx_timebase #(.CLKS_PER_US(CLKS_PER_US), .LEN_W(LEN_W)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .restart_i(edge_det),
    .period_i(timing_q[LEN_W-1:0]), .us_tick_o(us_tick), .smp_tick_o(smp_tick)
  );

  ir_rx_runlen #(.IDLE_US(IDLE_US)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .lvl_i(ir_s),
    .us_tick_i(us_tick), .smp_tick_i(smp_tick), .edge_o(edge_det),
    .smp_vld_o(smp_vld), .smp_o(smp)
  );

  ir_rx_sbuf u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .wr_i(smp_vld),
    .data_i(smp), .rd_addr_i(bus_addr_i[PTR_W-1:0]),
    .rd_data_o(buf_rdata), .half_o(half), .fill_o(fill)
  );

  always_comb begin
    en_d     = (bus_we_i && bus_addr_i == ADDR_CTRL)   ? bus_wdata_i[0] : en_q;
    timing_d = (bus_we_i && bus_addr_i == ADDR_TIMING) ? bus_wdata_i    : timing_q;
    ovf_hit  = smp_vld && (smp.len == LEN_SAT) && timing_q[SMP_W-1];
    irq_set  = fill || ovf_hit;
    irq_ack  = bus_we_i && (bus_addr_i == ADDR_STATUS) && bus_wdata_i[1];
    irq_d    = irq_set || (irq_q && !irq_ack);
  end

  always_comb begin
    if (!bus_addr_i[ADDR_W-1])           bus_rdata_o = buf_rdata;
    else if (bus_addr_i == ADDR_CTRL)    bus_rdata_o = {7'b0, en_q};
    else if (bus_addr_i == ADDR_TIMING)  bus_rdata_o = timing_q;
    else if (bus_addr_i == ADDR_STATUS)  bus_rdata_o = {6'b0, irq_q, half};
    else                                 bus_rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      timing_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      en_q     <= en_d;
      timing_q <= timing_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R5: a completed half raises the interrupt
  p_fill_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill |=> irq_o);
  // R6: a saturated byte with the option set raises the interrupt
  p_ovf_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_hit |=> irq_o);
  // R7: an acknowledge with no new cause drops the interrupt
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack && !irq_set) |=> !irq_o);
  // R9: nothing is stored while disabled
  p_no_store_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !smp_vld);
endmodule

// File: tb/ir_rx_sampler_tb_top.sv
module ir_rx_sampler_tb_top;
  localparam int CPU  = 4;
  localparam int IDLE = 400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ir;
  logic [3:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit mon_en = 0;
  int period = 2;
  logic [7:0] exp_q[$];
  logic       exp_half_q[$];

  always #4 clk = ~clk;

  ir_rx_sampler #(.CLKS_PER_US(CPU), .IDLE_US(IDLE), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  // driver: hold a level for n sample periods plus half a period
  task automatic run(input logic lvl, input int n);
    ir = lvl;
    repeat (n * CPU * period + (CPU * period) / 2) @(negedge clk);
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: drain a half on each interrupt and compare with the queue
  initial begin
    logic [7:0] st, b;
    forever begin
      @(negedge clk);
      if (mon_en && irq) begin
        bus_rd(4'hA, st);
        if (exp_half_q.size() > 0) check("R5 ready half", {7'b0, st[0]}, {7'b0, exp_half_q.pop_front()});
        else check("R5 unexpected half", 8'h00, 8'hFF);
        for (int i = 0; i < 4; i++) begin
          bus_rd({1'b0, st[0], 2'(i)}, b);
          if (exp_q.size() > 0) check("R1/R3/R4/R8 sample", b, exp_q.pop_front());
          else check("R8 unexpected sample", b, 8'hEE);
        end
        bus_wr(4'hA, 8'h02);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; ir = 1'b0; addr = '0; we = 1'b0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 irq", {7'b0, irq}, 8'h00);
    bus_rd(4'hA, v); check("R10 status", v, 8'h00);
    bus_rd(4'h9, v); check("R10 timing", v, 8'h00);
    bus_rd(4'h8, v); check("R10 control", v, 8'h00);

    // main sequence, period 2 us
    period = 2;
    bus_wr(4'h9, 8'h02);
    bus_wr(4'h8, 8'h01);
    mon_en = 1;
    repeat (20) @(negedge clk);
    exp_q.push_back(8'h05); exp_q.push_back(8'h83);
    exp_q.push_back(8'h0A); exp_q.push_back(8'h87); exp_half_q.push_back(1'b0);
    exp_q.push_back(8'h7F); exp_q.push_back(8'h03);   // R3 saturation then remainder
    exp_q.push_back(8'h94); exp_q.push_back(8'h01); exp_half_q.push_back(1'b1);
    exp_q.push_back(8'hFF);                            // R8 one saturated space only
    exp_q.push_back(8'h04); exp_q.push_back(8'h82);
    exp_q.push_back(8'h06); exp_half_q.push_back(1'b0);
    run(1, 5); run(0, 3); run(1, 10); run(0, 7);
    run(1, 130); run(0, 20); run(1, 1);
    ir = 1'b0; repeat (2500) @(negedge clk);
    run(1, 4); run(0, 2); run(1, 6);
    ir = 1'b0;
    for (int k = 0; k < 400 && exp_q.size() > 0; k++) @(negedge clk);
    repeat (40) @(negedge clk);
    check("R5 all samples drained", 8'(exp_q.size()), 8'h00);
    mon_en = 0;

    // R9 disable: no stores, pointer back to 0, period 3 us (R2)
    bus_wr(4'h8, 8'h00);
    period = 3;
    run(1, 3); run(0, 3);
    bus_rd(4'h2, v); check("R9 no store while disabled", v, 8'h82);
    bus_wr(4'h9, 8'h03);
    bus_wr(4'h8, 8'h01);
    repeat (20) @(negedge clk);
    run(1, 2); run(0, 5);
    ir = 1'b1; repeat (20) @(negedge clk);
    bus_rd(4'h0, v); check("R9 first byte at address 0", v, 8'h02);
    bus_rd(4'h1, v); check("R2 space of 5 periods at 3 us", v, 8'h85);
    check("R9 no interrupt for two bytes", {7'b0, irq}, 8'h00);
    ir = 1'b0;

    // R6 saturation interrupt enabled, period 1 us
    bus_wr(4'h8, 8'h00);
    period = 1;
    bus_wr(4'h9, 8'h81);
    bus_wr(4'h8, 8'h01);
    repeat (10) @(negedge clk);
    ir = 1'b1; repeat (130 * CPU + 2) @(negedge clk);
    check("R6 interrupt on saturated byte", {7'b0, irq}, 8'h01);
    bus_rd(4'h0, v); check("R3 saturated pulse byte", v, 8'h7F);
    bus_wr(4'hA, 8'h00);
    check("R7 write without ack bit keeps irq", {7'b0, irq}, 8'h01);
    bus_wr(4'hA, 8'h02);
    check("R7 ack clears irq", {7'b0, irq}, 8'h00);
    ir = 1'b0;

    // R6 saturation without the option
    bus_wr(4'h8, 8'h00);
    bus_wr(4'h9, 8'h01);
    bus_wr(4'h8, 8'h01);
    repeat (10) @(negedge clk);
    ir = 1'b1; repeat (130 * CPU + 2) @(negedge clk);
    check("R6 no interrupt with option clear", {7'b0, irq}, 8'h00);
    bus_rd(4'h0, v); check("R3 saturated byte stored", v, 8'h7F);
    ir = 1'b0;
    repeat (10) @(negedge clk);
    report();
  end
endmodule